// File: doc/BRIEF.md
# RAM ECC Error Injection Controller

This block sits between an ECC-protected RAM and its ECC decoder (and, optionally, between the ECC encoder and the RAM). When software asks for it, the block corrupts the codeword passing through. It flips one chosen bit to model a correctable error, or two chosen bits to model an uncorrectable one. Safety self-test software uses it to prove that the decoder and the error reporting downstream actually work.

Software programs the block through a small register write port. There are three registers: a control word, a 32-bit target row address, and a pair of 16-bit bit-index fields. On every RAM access the block checks the access address against the target row. In any-row mode it accepts every access instead. A matching access has the selected mask XORed into its codeword in the same cycle, and `inject_pulse` is raised for that cycle.

In one-shot mode the pending force request is used up by the first corrupted access. In persistent mode every matching access is corrupted. The generate, check and read-modify-write enables are driven out to the neighbouring ECC logic. When both the generate and check enables are off, the block is a transparent wire.

Top module: `ecc_inj_ctrl`

## Requirements
- R1: Register writes use `cfg_wr_sel` to pick the target. Selector 0 loads the control word: bit0 generate enable, bit1 check enable, bit2 read-modify-write enable, bit3 single force, bit4 double force, bit5 any-row, bit6 one-shot, bit7 write-through. Selector 1 loads the target row. Selector 2 loads the first bit index from data[15:0] and the second from data[31:16]. After reset the three enables read 1 on `gen_en_o`, `chk_en_o` and `rmw_en_o`, and all other control bits are 0, so accesses pass through clean.
- R2: With only the single force set, a matching access has exactly the bit at the first index inverted.
- R3: With the double force set, a matching access has the bits at both the first and second index inverted.
- R4: When both force bits are set, the double-bit injection is applied.
- R5: With any-row clear, only an access whose address, zero-extended to 32 bits, equals the full 32-bit target row is corrupted. Other accesses pass unchanged.
- R6: With any-row set, the target row is ignored and every access is eligible for injection.
- R7: With one-shot set, both force bits clear on the clock edge that ends the first corrupted access, and later accesses pass clean.
- R8: With one-shot clear, the force bits stay set and every matching access is corrupted.
- R9: Write accesses (`acc_write`=1) are corrupted on the write path only when write-through is set. Otherwise they pass clean. Reads are corrupted on the read path only.
- R10: When generate enable and check enable are both 0, no access is corrupted. Either enable alone is enough to allow injection.
- R11: `inject_pulse` is high exactly in the cycle of each corrupted access. When it is low, both codeword outputs equal their inputs.
- R12: An index at or above the codeword width flips no bit. A double injection with both indices equal flips that single bit.
- R13: A control-word write in the same cycle as a one-shot injection takes precedence over the self-clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 2 | Register select (0 control, 1 row, 2 bit indices) |
| cfg_wr_data | input | 32 | Register write data |
| acc_valid | input | 1 | RAM access in this cycle |
| acc_write | input | 1 | Access is a write (1) or a read (0) |
| acc_addr | input | ADDR_W | Row address of the access |
| rd_code_in | input | DATA_W | Codeword read from the RAM |
| wr_code_in | input | DATA_W | Codeword headed for the RAM |
| rd_code_out | output | DATA_W | Read codeword toward the decoder, possibly corrupted |
| wr_code_out | output | DATA_W | Write codeword toward the RAM, possibly corrupted |
| inject_pulse | output | 1 | High in the cycle of a corrupted access |
| gen_en_o | output | 1 | ECC generation enable to the encoder |
| chk_en_o | output | 1 | ECC check enable to the decoder |
| rmw_en_o | output | 1 | Read-modify-write enable to the RAM wrapper |

## Verification
The assertions assume that `acc_valid`, `acc_write` and the codeword inputs are stable over each clock cycle. Both codeword outputs are combinational on these inputs, so the assertions compare outputs with inputs at the sampling edge.

The one-shot and persistent properties assume that no control write lands in the cycle after an injection unless the test intends it. The bench keeps to this by driving one register write or one access per cycle, always on the falling edge. The only overlap it creates on purpose is the same-cycle case of R13. The one-shot property excludes that case through its `cfg_wr_en` guard.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

   // Control word; first member is the MSB, so gen_en lands on bit 0.
   typedef struct packed {
      logic wr_thru;
      logic once;
      logic any_row;
      logic frc_dbl;
      logic frc_sgl;
      logic rmw_en;
      logic chk_en;
      logic gen_en;
   } inj_ctrl_t;

   localparam int CTRL_W   = $bits(inj_ctrl_t);
   localparam int ROW_W    = 32;
   localparam int CFG_W    = 32;

   localparam inj_ctrl_t CTRL_RESET = '{
      wr_thru: 1'b0, once: 1'b0, any_row: 1'b0, frc_dbl: 1'b0,
      frc_sgl: 1'b0, rmw_en: 1'b1, chk_en: 1'b1, gen_en: 1'b1};

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_ROW  = 2'd1,
      SEL_BITS = 2'd2
   } cfg_sel_e;

endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
   import ecc_inj_pkg::*;
#(
   parameter int IDX_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [1:0]         wr_sel,
   input  logic [CFG_W-1:0]   wr_data,
   input  logic               consume,
   output inj_ctrl_t          ctrl,
   output logic [ROW_W-1:0]   row,
   output logic [IDX_W-1:0]   idx_a,
   output logic [IDX_W-1:0]   idx_b
);

   localparam int HALF = CFG_W / 2;

   initial begin
      assert (IDX_W >= 1 && IDX_W <= HALF)
         else $error("ecc_inj_regs: IDX_W must be between 1 and %0d", HALF);
   end

   logic wr_ctrl, wr_row, wr_bits;

   always_comb begin
      wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
      wr_row  = wr_en && (wr_sel == SEL_ROW);
      wr_bits = wr_en && (wr_sel == SEL_BITS);
   end

   // Control word: a software write wins over the one-shot self-clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= CTRL_RESET;
      end else if (wr_ctrl) begin
         ctrl <= inj_ctrl_t'(wr_data[CTRL_W-1:0]);
      end else if (consume && ctrl.once) begin
         ctrl.frc_sgl <= 1'b0;
         ctrl.frc_dbl <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row <= '0;
      end else if (wr_row) begin
         row <= wr_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_a <= '0;
         idx_b <= '0;
      end else if (wr_bits) begin
         idx_a <= wr_data[IDX_W-1:0];
         idx_b <= wr_data[HALF+IDX_W-1:HALF];
      end
   end

endmodule

// File: rtl/ecc_inj_match.sv
module ecc_inj_match
   import ecc_inj_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic               acc_valid,
   input  logic               acc_write,
   input  logic [ADDR_W-1:0]  acc_addr,
   input  logic [ROW_W-1:0]   row,
   input  logic               gen_en,
   input  logic               chk_en,
   input  logic               frc_sgl,
   input  logic               frc_dbl,
   input  logic               any_row,
   input  logic               wr_thru,
   output logic               hit
);

   initial begin
      assert (ADDR_W >= 1 && ADDR_W <= ROW_W)
         else $error("ecc_inj_match: ADDR_W must be between 1 and %0d", ROW_W);
   end

   logic row_eq;

   // Full-width compare: a narrow address is zero-extended to the row width.
   generate
      if (ADDR_W < ROW_W) begin : g_pad
         assign row_eq = ({{(ROW_W-ADDR_W){1'b0}}, acc_addr} == row);
      end else begin : g_full
         assign row_eq = (acc_addr == row);
      end
   endgenerate

   logic path_on, force_on, dir_ok, addr_ok;

   always_comb begin
      path_on  = gen_en | chk_en;
      force_on = frc_sgl | frc_dbl;
      dir_ok   = !acc_write || wr_thru;
      addr_ok  = any_row || row_eq;
      hit      = acc_valid && path_on && force_on && dir_ok && addr_ok;
   end

endmodule

// File: rtl/ecc_inj_mask.sv
module ecc_inj_mask #(
   parameter int DATA_W = 39,
   parameter int IDX_W  = 16
) (
   input  logic [IDX_W-1:0]  idx_a,
   input  logic [IDX_W-1:0]  idx_b,
   input  logic              dbl,
   output logic [DATA_W-1:0] mask
);

   initial begin
      assert (DATA_W >= 2 && DATA_W <= (1 << IDX_W))
         else $error("ecc_inj_mask: DATA_W must be between 2 and 2**IDX_W");
   end

   // One decoder slice per codeword bit; out-of-range indices select nothing.
   generate
      for (genvar g = 0; g < DATA_W; g++) begin : g_bit
         assign mask[g] = (idx_a == IDX_W'(g)) || (dbl && (idx_b == IDX_W'(g)));
      end
   endgenerate

endmodule

// File: rtl/ecc_inj_ctrl.sv
module ecc_inj_ctrl
   import ecc_inj_pkg::*;
#(
   parameter int DATA_W = 39,
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [1:0]        cfg_wr_sel,
   input  logic [31:0]       cfg_wr_data,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [DATA_W-1:0] rd_code_in,
   input  logic [DATA_W-1:0] wr_code_in,
   output logic [DATA_W-1:0] rd_code_out,
   output logic [DATA_W-1:0] wr_code_out,
   output logic              inject_pulse,
   output logic              gen_en_o,
   output logic              chk_en_o,
   output logic              rmw_en_o
);

   inj_ctrl_t          ctrl_q;
   logic [ROW_W-1:0]   row_q;
   logic [IDX_W-1:0]   idx_a_q, idx_b_q;
   logic               hit;
   logic [DATA_W-1:0]  flip_mask;

   ecc_inj_regs #(.IDX_W(IDX_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_sel  (cfg_wr_sel),
      .wr_data (cfg_wr_data),
      .consume (hit),
      .ctrl    (ctrl_q),
      .row     (row_q),
      .idx_a   (idx_a_q),
      .idx_b   (idx_b_q)
   );

   ecc_inj_match #(.ADDR_W(ADDR_W)) u_match (
      .acc_valid (acc_valid),
      .acc_write (acc_write),
      .acc_addr  (acc_addr),
      .row       (row_q),
      .gen_en    (ctrl_q.gen_en),
      .chk_en    (ctrl_q.chk_en),
      .frc_sgl   (ctrl_q.frc_sgl),
      .frc_dbl   (ctrl_q.frc_dbl),
      .any_row   (ctrl_q.any_row),
      .wr_thru   (ctrl_q.wr_thru),
      .hit       (hit)
   );

   // The double force takes priority: it alone decides whether the second index is used.
   ecc_inj_mask #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_mask (
      .idx_a (idx_a_q),
      .idx_b (idx_b_q),
      .dbl   (ctrl_q.frc_dbl),
      .mask  (flip_mask)
   );

   always_comb begin
      rd_code_out  = rd_code_in ^ ((hit && !acc_write) ? flip_mask : '0);
      wr_code_out  = wr_code_in ^ ((hit &&  acc_write) ? flip_mask : '0);
      inject_pulse = hit;
      gen_en_o     = ctrl_q.gen_en;
      chk_en_o     = ctrl_q.chk_en;
      rmw_en_o     = ctrl_q.rmw_en;
   end

endmodule

// File: rtl/ecc_inj_ctrl_chk.sv
module ecc_inj_ctrl_chk
   import ecc_inj_pkg::*;
#(
   parameter int DATA_W = 39
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_wr_en,
   input logic              acc_valid,
   input logic              acc_write,
   input logic [DATA_W-1:0] rd_code_in,
   input logic [DATA_W-1:0] rd_code_out,
   input logic [DATA_W-1:0] wr_code_in,
   input logic [DATA_W-1:0] wr_code_out,
   input logic              inject_pulse,
   input logic              gen_en_o,
   input logic              chk_en_o,
   input inj_ctrl_t         ctrl
);

   assert_bypass_R10: assert property (@(posedge clk) disable iff (!rst_n)
      inject_pulse |-> (gen_en_o || chk_en_o));

   assert_pulse_needs_access_R11: assert property (@(posedge clk) disable iff (!rst_n)
      inject_pulse |-> acc_valid);

   assert_clean_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !inject_pulse |-> (rd_code_out == rd_code_in) && (wr_code_out == wr_code_in));

   assert_at_most_two_flips_R3: assert property (@(posedge clk) disable iff (!rst_n)
      inject_pulse |-> ($countones(rd_code_out ^ rd_code_in) <= 2)
                    && ($countones(wr_code_out ^ wr_code_in) <= 2));

   assert_single_one_flip_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (inject_pulse && ctrl.frc_sgl && !ctrl.frc_dbl)
         |-> ($countones(rd_code_out ^ rd_code_in) <= 1)
          && ($countones(wr_code_out ^ wr_code_in) <= 1));

   assert_write_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !ctrl.wr_thru) |-> !inject_pulse);

   assert_oneshot_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inject_pulse && ctrl.once && !cfg_wr_en) |=> !inject_pulse);

   assert_persistent_force_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (inject_pulse && !ctrl.once && !cfg_wr_en)
         |=> (ctrl.frc_sgl == $past(ctrl.frc_sgl)) && (ctrl.frc_dbl == $past(ctrl.frc_dbl)));

endmodule

bind ecc_inj_ctrl ecc_inj_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_wr_en    (cfg_wr_en),
   .acc_valid    (acc_valid),
   .acc_write    (acc_write),
   .rd_code_in   (rd_code_in),
   .rd_code_out  (rd_code_out),
   .wr_code_in   (wr_code_in),
   .wr_code_out  (wr_code_out),
   .inject_pulse (inject_pulse),
   .gen_en_o     (gen_en_o),
   .chk_en_o     (chk_en_o),
   .ctrl         (ctrl_q)
);

// File: tb/test_ecc_inj_ctrl.sv
module test_ecc_inj_ctrl;

   localparam int W  = 8;
   localparam int AW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_wr_en = 1'b0;
   logic [1:0]    cfg_wr_sel = '0;
   logic [31:0]   cfg_wr_data = '0;
   logic          acc_valid = 1'b0;
   logic          acc_write = 1'b0;
   logic [AW-1:0] acc_addr = '0;
   logic [W-1:0]  rd_code_in = '0;
   logic [W-1:0]  wr_code_in = '0;
   logic [W-1:0]  rd_code_out, wr_code_out;
   logic          inject_pulse, gen_en_o, chk_en_o, rmw_en_o;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   ecc_inj_ctrl #(.DATA_W(W), .ADDR_W(AW)) i_ecc_inj_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
      .cfg_wr_data(cfg_wr_data), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_addr(acc_addr), .rd_code_in(rd_code_in), .wr_code_in(wr_code_in),
      .rd_code_out(rd_code_out), .wr_code_out(wr_code_out),
      .inject_pulse(inject_pulse), .gen_en_o(gen_en_o), .chk_en_o(chk_en_o),
      .rmw_en_o(rmw_en_o));

   // Control word layout from R1.
   function automatic logic [31:0] cw(bit gen, bit chk, bit rmw, bit fs, bit fd,
                                      bit any, bit once, bit wt);
      return {24'd0, wt, once, any, fd, fs, rmw, chk, gen};
   endfunction

   function automatic logic [W-1:0] bitmask(int a, int b, bit dbl);
      logic [W-1:0] m = '0;
      if (a < W) m[a] = 1'b1;
      if (dbl && b < W) m[b] = 1'b1;
      return m;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cfg(logic [1:0] sel, logic [31:0] data);
      @(negedge clk);
      cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = data;
      @(posedge clk); #1;
      cfg_wr_en = 1'b0;
   endtask

   // One access; samples before the edge, then lets the edge pass.
   task automatic access(bit wr, logic [AW-1:0] addr, logic [W-1:0] data,
                         output logic [W-1:0] rd_o, output logic [W-1:0] wr_o,
                         output logic pulse);
      @(negedge clk);
      acc_valid = 1'b1; acc_write = wr; acc_addr = addr;
      rd_code_in = data; wr_code_in = data;
      #1;
      rd_o = rd_code_out; wr_o = wr_code_out; pulse = inject_pulse;
      @(posedge clk); #1;
      acc_valid = 1'b0;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_err++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] r, w, d;
      logic p;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      #1;
      check("R1 gen_en", 32'(gen_en_o), 32'd1);
      check("R1 chk_en", 32'(chk_en_o), 32'd1);
      check("R1 rmw_en", 32'(rmw_en_o), 32'd1);
      access(1'b0, 8'h00, 8'h3C, r, w, p);
      check("R1 read clean", 32'(r), 32'h3C);
      check("R1 no pulse", 32'(p), 32'd0);

      // R2/R12: sweep single index including out-of-range values
      cfg(2'd0, cw(1,1,1, 1,0, 1,0,0));
      for (int i = 0; i < W + 2; i++) begin
         d = W'(8'h5A + i);
         cfg(2'd2, {16'd7, 16'(i)});
         access(1'b0, AW'(i * 3), d, r, w, p);
         check($sformatf("R2 single idx %0d", i), 32'(r), 32'(d ^ bitmask(i, 0, 0)));
         check("R11 pulse single", 32'(p), 32'd1);
      end

      // R3/R12: sweep all index pairs for double
      cfg(2'd0, cw(1,1,1, 0,1, 1,0,0));
      for (int a = 0; a < W; a++) begin
         for (int b = 0; b < W; b++) begin
            d = W'(a * 17 + b * 5);
            cfg(2'd2, {16'(b), 16'(a)});
            access(1'b0, 8'h11, d, r, w, p);
            check($sformatf("R3 double %0d,%0d", a, b), 32'(r), 32'(d ^ bitmask(a, b, 1)));
         end
      end
      cfg(2'd2, {16'd9, 16'd2});
      access(1'b0, 8'h11, 8'h00, r, w, p);
      check("R12 second index out of range", 32'(r), 32'h04);

      // R4: both forces set, double wins
      cfg(2'd2, {16'd6, 16'd1});
      cfg(2'd0, cw(1,1,1, 1,1, 1,0,0));
      access(1'b0, 8'h20, 8'h00, r, w, p);
      check("R4 double priority", 32'(r), 32'h42);

      // R5: row match with full-width compare
      cfg(2'd0, cw(1,1,1, 1,0, 0,0,0));
      cfg(2'd1, 32'h0000_005A);
      access(1'b0, 8'h5A, 8'hF0, r, w, p);
      check("R5 row hit", 32'(r), 32'hF2);
      access(1'b0, 8'h5B, 8'hF0, r, w, p);
      check("R5 row miss data", 32'(r), 32'hF0);
      check("R11 miss no pulse", 32'(p), 32'd0);
      cfg(2'd1, 32'h0000_015A);
      access(1'b0, 8'h5A, 8'hF0, r, w, p);
      check("R5 upper row bits", 32'(r), 32'hF0);

      // R6: any-row ignores the target row
      cfg(2'd0, cw(1,1,1, 1,0, 1,0,0));
      access(1'b0, 8'h33, 8'hF0, r, w, p);
      check("R6 any row", 32'(r), 32'hF2);

      // R7: one-shot
      cfg(2'd1, 32'h0000_0044);
      cfg(2'd0, cw(1,1,1, 1,0, 0,1,0));
      access(1'b0, 8'h45, 8'h10, r, w, p);
      check("R7 miss keeps request", 32'(r), 32'h10);
      access(1'b0, 8'h44, 8'h10, r, w, p);
      check("R7 first hit", 32'(r), 32'h12);
      check("R11 pulse one-shot", 32'(p), 32'd1);
      access(1'b0, 8'h44, 8'h10, r, w, p);
      check("R7 second clean", 32'(r), 32'h10);
      check("R7 second no pulse", 32'(p), 32'd0);

      // R8: persistent
      cfg(2'd0, cw(1,1,1, 1,0, 0,0,0));
      for (int k = 0; k < 3; k++) begin
         access(1'b0, 8'h44, 8'h80, r, w, p);
         check($sformatf("R8 persistent %0d", k), 32'(r), 32'h82);
      end

      // R9: write path gating
      access(1'b1, 8'h44, 8'h80, r, w, p);
      check("R9 write no thru", 32'(w), 32'h80);
      check("R9 write no pulse", 32'(p), 32'd0);
      cfg(2'd0, cw(1,1,1, 1,0, 0,0,1));
      access(1'b1, 8'h44, 8'h80, r, w, p);
      check("R9 write thru", 32'(w), 32'h82);
      check("R9 read path untouched", 32'(r), 32'h80);
      access(1'b0, 8'h44, 8'h80, r, w, p);
      check("R9 read corrupt", 32'(r), 32'h82);
      check("R9 write path untouched", 32'(w), 32'h80);

      // R10: bypass
      cfg(2'd0, cw(0,0,1, 1,0, 1,0,0));
      #1;
      check("R10 gen off", 32'(gen_en_o), 32'd0);
      check("R10 chk off", 32'(chk_en_o), 32'd0);
      access(1'b0, 8'h44, 8'h80, r, w, p);
      check("R10 bypass clean", 32'(r), 32'h80);
      check("R10 bypass no pulse", 32'(p), 32'd0);
      cfg(2'd0, cw(0,1,1, 1,0, 1,0,0));
      access(1'b0, 8'h44, 8'h80, r, w, p);
      check("R10 check only injects", 32'(r), 32'h82);
      cfg(2'd0, cw(1,0,0, 1,0, 1,0,0));
      #1;
      check("R1 rmw follows write", 32'(rmw_en_o), 32'd0);
      access(1'b0, 8'h44, 8'h80, r, w, p);
      check("R10 gen only injects", 32'(r), 32'h82);

      // R13: control write in the same cycle as a one-shot injection
      cfg(2'd0, cw(1,1,1, 1,0, 1,1,0));
      @(negedge clk);
      acc_valid = 1'b1; acc_write = 1'b0; acc_addr = 8'h01; rd_code_in = 8'h00;
      cfg_wr_en = 1'b1; cfg_wr_sel = 2'd0; cfg_wr_data = cw(1,1,1, 1,0, 1,1,0);
      #1;
      check("R13 overlap hit", 32'(rd_code_out), 32'h02);
      @(posedge clk); #1;
      acc_valid = 1'b0; cfg_wr_en = 1'b0;
      access(1'b0, 8'h01, 8'h00, r, w, p);
      check("R13 write wins", 32'(r), 32'h02);
      access(1'b0, 8'h01, 8'h00, r, w, p);
      check("R13 then consumed", 32'(r), 32'h00);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule